// File: doc/BRIEF.md
# PECI Host Controller Register Stub

This block stands in for a platform environment control interface host controller. A command never goes out on a wire. It finishes in the same clock edge that accepts it. Software sees a small 32-bit register file on a simple strobe bus with a byte offset, and the block drives one level-sensitive interrupt line. It is meant for system models and early firmware bring-up, where a driver has to see a command complete with a success code and a done interrupt. The wire protocol, data lengths, transfer timing and client devices are not modelled.

A write of 1 to the fire bit of the command word loads the success completion code `0x40` into the first word of the outgoing buffer and the first word of the incoming buffer. It then replaces the status word with the enabled done cause. A fire request is dropped while any status bit is still pending. Status bits are cleared by writing ones to them. The interrupt line follows the status word.

Top module: `peci_host_stub`

## Requirements
- R1: After reset every register word reads 0, `irq` is low and `rdata` is 0.
- R2: Any in-range word other than the command word (0x08) and the status word (0x1C) stores all 32 bits of a write. That includes the enable word 0x18, the outgoing buffer from 0x20 and the incoming buffer from 0x30. Address bits [1:0] are ignored.
- R3: The command word (0x08) always reads 0. A command write with bit 0 clear changes no register and leaves `irq` unchanged.
- R4: A command write with bit 0 set while the status word is 0 is accepted. It writes 0x40 into word 0x20 and word 0x30 and leaves every other buffer word unchanged.
- R5: On an accepted fire the status word (0x1C) becomes the enable word ANDed with the done bit (bit 0). The new value replaces the old status, so no other bit is ever set.
- R6: `irq` rises on the clock edge that accepts a fire only if enable bit 0 is set. Otherwise it stays low.
- R7: A fire request that arrives while the status word is nonzero is dropped. No register changes and `irq` stays high.
- R8: A write to the status word clears each bit that is 1 in the written data. `irq` falls on the same edge that makes the status word 0 and stays high while any status bit remains.
- R9: A write at a byte offset at or above 0x40 changes no register. A read there returns 0.
- R10: `rdata` is the addressed word captured on the clock edge where `rd_en` is high, so a read in the same cycle as a write returns the value before the write. `rdata` holds while `rd_en` is low.
- R11: At every clock edge `irq` is high exactly when the status word is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; data appears on `rdata` after the next edge |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt, high while status is pending |

## Verification
Several properties are checked on every cycle:
- the interrupt line must equal "status nonzero";
- the command word must never hold data;
- a status write must never add bits;
- a fire that is dropped or has bit 0 clear must leave the whole register file stable;
- an accepted fire must leave the success code in both buffers and the enable-masked done bit in status;
- an out-of-range access must change nothing and return 0;
- `rdata` must hold while no read is strobed.

Only the directed scenarios can show the rest. They show that ordinary words keep their data across the address aliases, that the enable gating holds under both enable settings and with upper enable bits set, and the ordering of a read and a write to the same word in one cycle.

// File: rtl/pst_pkg.sv
package pst_pkg;

    // Word indices whose position the behaviour depends on
    localparam int CMD_WORD  = 2;   // byte 0x08
    localparam int EN_WORD   = 6;   // byte 0x18
    localparam int STS_WORD  = 7;   // byte 0x1C
    localparam int WBUF_WORD = 8;   // byte 0x20
    localparam int RBUF_WORD = 12;  // byte 0x30

    localparam int FIRE_BIT = 0;
    localparam int DONE_BIT = 0;

    localparam logic [31:0] CC_SUCCESS = 32'h0000_0040;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_PLAIN = 2'd1,
        ACC_CMD   = 2'd2,
        ACC_STS   = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/pst_addr_dec.sv
module pst_addr_dec
    import pst_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_WORDS = 16,
    localparam int IDX_W    = $clog2(NUM_WORDS),
    localparam int WA_W     = ADDR_W - 2
) (
    input  logic [WA_W-1:0]      word_addr,
    output logic                 hit,
    output logic [IDX_W-1:0]     idx,
    output acc_kind_e            kind,
    output logic [NUM_WORDS-1:0] sel
);

    always_comb begin
        hit = ({1'b0, word_addr} < (WA_W+1)'(NUM_WORDS));
        idx = word_addr[IDX_W-1:0];
        if (!hit) begin
            kind = ACC_NONE;
        end else if (idx == IDX_W'(CMD_WORD)) begin
            kind = ACC_CMD;
        end else if (idx == IDX_W'(STS_WORD)) begin
            kind = ACC_STS;
        end else begin
            kind = ACC_PLAIN;
        end
    end

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_sel
        assign sel[i] = hit && (idx == IDX_W'(i));
    end

endmodule

// File: rtl/pst_regfile.sv
module pst_regfile
    import pst_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 16,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  acc_kind_e                         kind,
    input  logic [IDX_W-1:0]                  idx,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [NUM_WORDS-1:0][DATA_W-1:0]  regs,
    output logic                              irq
);

    localparam logic [DATA_W-1:0] DONE_MASK = DATA_W'(1) << DONE_BIT;
    localparam logic [DATA_W-1:0] CC_WORD   = DATA_W'(CC_SUCCESS);

    typedef struct packed {
        logic [NUM_WORDS-1:0][DATA_W-1:0] regs;
        logic                             irq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (kind)
                ACC_STS: begin
                    st_d.regs[STS_WORD] = st_q.regs[STS_WORD] & ~wdata;
                    if (st_d.regs[STS_WORD] == '0) begin
                        st_d.irq = 1'b0;
                    end
                end
                ACC_CMD: begin
                    if (wdata[FIRE_BIT] && (st_q.regs[STS_WORD] == '0)) begin
                        st_d.regs[RBUF_WORD] = CC_WORD;
                        st_d.regs[WBUF_WORD] = CC_WORD;
                        st_d.regs[STS_WORD]  = st_q.regs[EN_WORD] & DONE_MASK;
                        if (st_d.regs[STS_WORD] != '0) begin
                            st_d.irq = 1'b1;
                        end
                    end
                end
                ACC_PLAIN: begin
                    st_d.regs[idx] = wdata;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs = st_q.regs;
    assign irq  = st_q.irq;

    // R11: interrupt level mirrors pending status
    a_r11_irq_tracks_status: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq == (st_q.regs[STS_WORD] != '0));

    // R3: command word never holds data
    a_r3_cmd_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.regs[CMD_WORD] == '0);

    // R3: command write without the fire bit is a no-op
    a_r3_nofire_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_CMD && !wdata[FIRE_BIT]) |=> $stable(st_q));

    // R7: fire while status pending leaves all state alone
    a_r7_pending_fire_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_CMD && st_q.regs[STS_WORD] != '0) |=> $stable(st_q));

    // R4, R5: accepted fire loads both buffers and masked done status
    a_r4_fire_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_CMD && wdata[FIRE_BIT] && st_q.regs[STS_WORD] == '0)
        |=> (st_q.regs[RBUF_WORD] == CC_WORD) && (st_q.regs[WBUF_WORD] == CC_WORD)
            && ((st_q.regs[STS_WORD] & ~DONE_MASK) == '0)
            && (st_q.regs[STS_WORD][DONE_BIT] == $past(st_q.regs[EN_WORD][DONE_BIT])));

    // R8: a status write never adds a bit
    a_r8_status_never_gains: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_STS)
        |=> ((st_q.regs[STS_WORD] & ~$past(st_q.regs[STS_WORD])) == '0));

    // R9: out-of-range writes are dropped
    a_r9_oob_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_NONE) |=> $stable(st_q));

endmodule

// File: rtl/pst_rd_port.sv
module pst_rd_port #(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rd_en,
    input  logic [NUM_WORDS-1:0]              sel,
    input  logic [NUM_WORDS-1:0][DATA_W-1:0]  regs,
    output logic [DATA_W-1:0]                 rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [NUM_WORDS-1:0][DATA_W-1:0] masked;
    logic [DATA_W-1:0] mux;

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_mask
        assign masked[i] = sel[i] ? regs[i] : '0;
    end

    always_comb begin
        mux = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            mux = mux | masked[i];
        end
        rd_d = rd_q;
        if (rd_en) begin
            rd_d.data = mux;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata = rd_q.data;

    // R9: reads that select no word return zero
    a_r9_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == '0) |=> (rd_q.data == '0));

    // R10: data holds between reads
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_q.data));

endmodule

// File: rtl/peci_host_stub.sv
module peci_host_stub
    import pst_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    localparam int IDX_W = $clog2(NUM_WORDS);
    localparam int WA_W  = ADDR_W - 2;

    logic                             unused_lowbits;
    logic                             hit;
    logic [IDX_W-1:0]                 idx;
    acc_kind_e                        kind;
    logic [NUM_WORDS-1:0]             sel;
    logic [NUM_WORDS-1:0][DATA_W-1:0] regs;

    assign unused_lowbits = ^addr[1:0];

    pst_addr_dec #(
        .ADDR_W    (ADDR_W),
        .NUM_WORDS (NUM_WORDS)
    ) u_dec (
        .word_addr (addr[ADDR_W-1:2]),
        .hit       (hit),
        .idx       (idx),
        .kind      (kind),
        .sel       (sel)
    );

    pst_regfile #(
        .DATA_W    (DATA_W),
        .NUM_WORDS (NUM_WORDS)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .kind  (kind),
        .idx   (idx),
        .wdata (wdata),
        .regs  (regs),
        .irq   (irq)
    );

    pst_rd_port #(
        .DATA_W    (DATA_W),
        .NUM_WORDS (NUM_WORDS)
    ) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (rd_en),
        .sel   (sel),
        .regs  (regs),
        .rdata (rdata)
    );

    // R9: the decoder never selects a word for an out-of-range offset
    a_r9_hit_matches_range: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit) |-> (sel == '0) && (kind == ACC_NONE));

    initial begin
        assert (WA_W >= IDX_W) else $error("address too narrow for register file");
    end

endmodule

// File: tb/peci_host_stub_test.sv
module peci_host_stub_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0;
    int bad = 0;

    peci_host_stub uut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        rd_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1;
        addr  = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 rdata", rdata, 32'h0);
        for (int i = 0; i < 16; i++) begin
            rd(8'(i * 4), v);
            chk("R1 word", v, 32'h0);
        end
    endtask

    task automatic t_plain_store();
        logic [31:0] v;
        do_reset();
        wr(8'h00, 32'hCAFE_0001);
        wr(8'h18, 32'hFFFF_FFFE);
        wr(8'h25, 32'h1234_5678);      // low bits ignored: word 0x24
        wr(8'h3E, 32'h8000_0001);      // word 0x3C
        rd(8'h00, v); chk("R2 word00", v, 32'hCAFE_0001);
        rd(8'h18, v); chk("R2 enable", v, 32'hFFFF_FFFE);
        rd(8'h24, v); chk("R2 alias", v, 32'h1234_5678);
        rd(8'h3C, v); chk("R2 last", v, 32'h8000_0001);
        rd(8'h27, v); chk("R2 rd alias", v, 32'h1234_5678);
    endtask

    task automatic t_cmd_nofire();
        logic [31:0] v;
        do_reset();
        wr(8'h18, 32'h1);
        wr(8'h08, 32'hFFFF_FFFE);
        chk("R3 irq", {31'b0, irq}, 32'h0);
        rd(8'h08, v); chk("R3 cmd zero", v, 32'h0);
        rd(8'h1C, v); chk("R3 status", v, 32'h0);
        rd(8'h30, v); chk("R3 rbuf", v, 32'h0);
    endtask

    task automatic t_fire_enabled();
        logic [31:0] v;
        do_reset();
        wr(8'h34, 32'h0000_0077);
        wr(8'h18, 32'hFFFF_FFFF);      // upper enable bits must not leak
        wr(8'h08, 32'h1);
        chk("R6 irq rise", {31'b0, irq}, 32'h1);
        rd(8'h20, v); chk("R4 wbuf", v, 32'h40);
        rd(8'h30, v); chk("R4 rbuf", v, 32'h40);
        rd(8'h34, v); chk("R4 other", v, 32'h77);
        rd(8'h1C, v); chk("R5 status", v, 32'h1);
        rd(8'h08, v); chk("R3 cmd after fire", v, 32'h0);
    endtask

    task automatic t_fire_disabled();
        logic [31:0] v;
        do_reset();
        wr(8'h18, 32'hFFFF_FFFE);
        wr(8'h08, 32'h1);
        chk("R6 no irq", {31'b0, irq}, 32'h0);
        rd(8'h1C, v); chk("R5 status masked", v, 32'h0);
        rd(8'h30, v); chk("R4 rbuf", v, 32'h40);
        wr(8'h30, 32'h0);
        wr(8'h08, 32'h1);               // status zero: accepted again
        rd(8'h30, v); chk("R4 refire", v, 32'h40);
    endtask

    task automatic t_fire_pending();
        logic [31:0] v;
        do_reset();
        wr(8'h18, 32'h1);
        wr(8'h08, 32'h1);
        wr(8'h20, 32'h0000_1234);
        wr(8'h30, 32'h0000_0055);
        wr(8'h08, 32'h1);
        chk("R7 irq held", {31'b0, irq}, 32'h1);
        rd(8'h20, v); chk("R7 wbuf kept", v, 32'h1234);
        rd(8'h30, v); chk("R7 rbuf kept", v, 32'h55);
        rd(8'h1C, v); chk("R7 status", v, 32'h1);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        do_reset();
        wr(8'h18, 32'h1);
        wr(8'h08, 32'h1);
        wr(8'h1C, 32'h0);
        chk("R8 zero write", {31'b0, irq}, 32'h1);
        wr(8'h1C, 32'hFFFF_FFFE);
        chk("R8 other bits", {31'b0, irq}, 32'h1);
        rd(8'h1C, v); chk("R8 status kept", v, 32'h1);
        wr(8'h1C, 32'h1);
        chk("R8 irq falls", {31'b0, irq}, 32'h0);
        rd(8'h1C, v); chk("R8 status clear", v, 32'h0);
        wr(8'h08, 32'h1);
        chk("R8 fire after clear", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_oob();
        logic [31:0] v;
        do_reset();
        wr(8'h00, 32'hAAAA_5555);
        wr(8'h40, 32'hDEAD_BEEF);
        wr(8'h5C, 32'hFFFF_FFFF);
        wr(8'hC8, 32'h1);
        chk("R9 irq", {31'b0, irq}, 32'h0);
        rd(8'h00, v); chk("R9 word0 kept", v, 32'hAAAA_5555);
        rd(8'h1C, v); chk("R9 status kept", v, 32'h0);
        rd(8'h40, v); chk("R9 read zero", v, 32'h0);
        rd(8'hFC, v); chk("R9 read top", v, 32'h0);
    endtask

    task automatic t_rw_same();
        logic [31:0] v;
        do_reset();
        wr(8'h04, 32'h0000_000A);
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = 8'h04; wdata = 32'h0000_000B;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R10 old value", rdata, 32'hA);
        repeat (3) @(negedge clk);
        chk("R10 hold", rdata, 32'hA);
        rd(8'h04, v); chk("R10 new value", v, 32'hB);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_plain_store();
        t_cmd_nofire();
        t_fire_enabled();
        t_fire_disabled();
        t_fire_pending();
        t_w1c();
        t_oob();
        t_rw_same();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule